// File: doc/BRIEF.md
# Life-Cycle Retirement Sequencer

This block tracks the life-cycle of a secure device and carries out the return-for-analysis (RMA) retirement flow. Retirement needs three separate events. First, a sticky one-time-programmable RMA flag is set. A power-on reset then makes retirement available. An explicit RMA command marks the device as pending. A second power-on reset wipes a small internal key store and leaves the device permanently inoperable. The key store holds sixteen words. Word 0 holds the device root key.

Two kinds of storage are modelled. The OTP flag, the pending and retired records and the key store stand for non-volatile storage: only the cold reset `rst_n` clears them. The power-on reset pulse `por_i` restarts only the volatile sequencer. After each POR, the sequencer spends one cycle in BOOT. In that cycle it picks its next state from the non-volatile records, with this priority: retired, then pending, then OTP flag.

The sequencer has six states and these transitions:
- BOOT goes to RETIRED, WIPE, AVAIL or NORMAL, as set by the priority above.
- NORMAL stays where it is.
- AVAIL goes to PEND on an RMA command.
- PEND stays where it is.
- WIPE goes to RETIRED on the last zero write.
- RETIRED stays where it is.
- Any state goes to BOOT on `por_i`.

Top module: `lcs_rma_seq`

## Requirements
- R1: After cold reset and one BOOT cycle, the life-cycle code is 00 (normal) and `operable_o` is high.
- R2: Setting the OTP RMA flag does not change the code until the next POR. After that POR the code reads 01 (RMA available).
- R3: An RMA command while the code is 01 moves the code to 10 (RMA pending) on the next cycle. `operable_o` stays high and no error is raised.
- R4: An RMA command in any state other than RMA available is ignored. The code is unchanged and `err_o` pulses high for exactly one cycle.
- R5: A POR while the pending record is set starts a wipe. The wipe writes zero to each of the 16 key-store words, one per clock. `zero_busy_o` is high for exactly 16 cycles and `operable_o` is low throughout.
- R6: `zero_done_o` pulses for one cycle right after the last zero write. From that cycle on, the code is 11 (retired) and `operable_o` is low.
- R7: The retired state persists through later POR pulses.
- R8: In the retired state, RMA commands and key-store reads and writes are rejected. Each rejection gives a one-cycle `err_o` pulse and no key data.
- R9: A life-cycle read request returns the current code on `lcs_rdata_o`, with `lcs_valid_o` high exactly one cycle later. This holds in every state, retired included.
- R10: While a wipe runs, key-store reads give no `key_rvalid_o` and a zero `key_rdata_o`, and they raise `err_o`.
- R11: A POR during a wipe restarts the wipe from word 0. The full 16 cycles of zero writes then follow.
- R12: While operable, a key read returns the word last written at that address. The data comes with `key_rvalid_o` one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, active low; clears non-volatile models too |
| por_i | input | 1 | Power-on reset pulse; restarts the sequencer only |
| otp_rma_set_i | input | 1 | Programs the sticky OTP RMA flag |
| rma_cmd_i | input | 1 | RMA service command strobe |
| lcs_rd_i | input | 1 | Life-cycle read request |
| lcs_valid_o | output | 1 | Read response valid, one cycle after request |
| lcs_rdata_o | output | 2 | Life-cycle code returned by the read |
| lcs_code_o | output | 2 | Current life-cycle code (00/01/10/11) |
| operable_o | output | 1 | High when services are accepted |
| err_o | output | 1 | One-cycle rejection flag |
| key_wr_i | input | 1 | Key-store write request |
| key_rd_i | input | 1 | Key-store read request |
| key_addr_i | input | 4 | Key-store word address |
| key_wdata_i | input | 32 | Key-store write data |
| key_rdata_o | output | 32 | Key-store read data |
| key_rvalid_o | output | 1 | Key-store read data valid |
| zero_busy_o | output | 1 | Wipe in progress |
| zero_done_o | output | 1 | One-cycle pulse at wipe completion |

## Verification
Some behaviours are checked by the assertions on every cycle:
- Every cycle of a wipe writes zero into the addressed word.
- PEND can only be entered from AVAIL by a command.
- Entering RETIRED from WIPE follows the last zero write.
- The retired record never clears.
- Read responses arrive one cycle after the request.
- No key data leaves during a wipe.

Other behaviours can only be shown by the bench's scenarios:
- The multi-step order of retirement: OTP flag, then POR, then command, then a second POR.
- The exact wipe length and the single done pulse.
- A wipe restarting after an interrupting POR.
- Commands being ignored in each wrong state.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_NORMAL,
        ST_AVAIL,
        ST_PEND,
        ST_WIPE,
        ST_RETIRED
    } lc_state_e;

    localparam logic [1:0] LC_NORMAL  = 2'b00;
    localparam logic [1:0] LC_AVAIL   = 2'b01;
    localparam logic [1:0] LC_PEND    = 2'b10;
    localparam logic [1:0] LC_RETIRED = 2'b11;

endpackage

// File: rtl/lcs_nv_record.sv
module lcs_nv_record (
    input  logic clk,
    input  logic rst_n,
    input  logic otp_set_i,
    input  logic pend_set_i,
    input  logic ret_set_i,
    output logic otp_flag_o,
    output logic pend_o,
    output logic ret_o
);

    logic otp_q, pend_q, ret_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            otp_q  <= 1'b0;
            pend_q <= 1'b0;
            ret_q  <= 1'b0;
        end else begin
            if (otp_set_i)  otp_q  <= 1'b1;
            if (pend_set_i) pend_q <= 1'b1;
            if (ret_set_i)  ret_q  <= 1'b1;
        end
    end

    assign otp_flag_o = otp_q;
    assign pend_o     = pend_q;
    assign ret_o      = ret_q;

    AST_RETIRED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ret_q |=> ret_q); // R7

endmodule

// File: rtl/lcs_keystore.sv
module lcs_keystore #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic          rd_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          zreq_i,
    output logic [DW-1:0] rdata_o,
    output logic          rvalid_o,
    output logic          zlast_o,
    output logic          zdone_o
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [DW-1:0] mem_q [DEPTH];
    logic [AW-1:0] idx_q;
    logic [DW-1:0] rdata_q;
    logic          rvalid_q;
    logic          zdone_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) mem_q[w] <= '0;
        end else if (zreq_i) begin
            mem_q[idx_q] <= '0;
        end else if (wr_en_i) begin
            mem_q[addr_i] <= wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            zdone_q <= 1'b0;
        end else begin
            idx_q   <= zreq_i ? idx_q + 1'b1 : '0;
            zdone_q <= zlast_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd_en_i;
            rdata_q  <= rd_en_i ? mem_q[addr_i] : '0;
        end
    end

    assign zlast_o  = zreq_i && (idx_q == LAST_IDX);
    assign zdone_o  = zdone_q;
    assign rdata_o  = rdata_q;
    assign rvalid_o = rvalid_q;

    AST_WIPE_WRITES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        zreq_i |=> (mem_q[$past(idx_q)] == '0)); // R5

    AST_WIPE_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zreq_i) |-> (idx_q == '0)); // R11

endmodule

// File: rtl/lcs_fsm.sv
module lcs_fsm
    import lcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_i,
    input  logic       rma_cmd_i,
    input  logic       key_acc_i,
    input  logic       otp_flag_i,
    input  logic       pend_i,
    input  logic       ret_i,
    input  logic       zlast_i,
    output logic [1:0] code_o,
    output logic       operable_o,
    output logic       key_ok_o,
    output logic       zreq_o,
    output logic       pend_set_o,
    output logic       ret_set_o,
    output logic       busy_o,
    output logic       err_o
);

    lc_state_e state_q, state_d;
    logic      err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state_q <= ST_BOOT;
        else if (por_i) state_q <= ST_BOOT;
        else            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: begin
                if (ret_i)           state_d = ST_RETIRED;
                else if (pend_i)     state_d = ST_WIPE;
                else if (otp_flag_i) state_d = ST_AVAIL;
                else                 state_d = ST_NORMAL;
            end
            ST_NORMAL:  state_d = ST_NORMAL;
            ST_AVAIL:   if (rma_cmd_i) state_d = ST_PEND;
            ST_PEND:    state_d = ST_PEND;
            ST_WIPE:    if (zlast_i) state_d = ST_RETIRED;
            ST_RETIRED: state_d = ST_RETIRED;
        endcase
    end

    always_comb begin
        code_o     = LC_NORMAL;
        operable_o = 1'b0;
        busy_o     = 1'b0;
        unique case (state_q)
            ST_BOOT:    code_o = LC_NORMAL;
            ST_NORMAL:  begin code_o = LC_NORMAL;  operable_o = 1'b1; end
            ST_AVAIL:   begin code_o = LC_AVAIL;   operable_o = 1'b1; end
            ST_PEND:    begin code_o = LC_PEND;    operable_o = 1'b1; end
            ST_WIPE:    begin code_o = LC_PEND;    busy_o     = 1'b1; end
            ST_RETIRED: code_o = LC_RETIRED;
        endcase
        zreq_o     = busy_o && !por_i;
        key_ok_o   = key_acc_i && operable_o;
        pend_set_o = (state_q == ST_AVAIL) && rma_cmd_i && !por_i;
        ret_set_o  = (state_q == ST_WIPE) && zlast_i && !por_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= (rma_cmd_i && state_q != ST_AVAIL)
                          || (key_acc_i && !operable_o);
    end

    assign err_o = err_q;

    AST_PEND_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND && $past(state_q) != ST_PEND)
            |-> ($past(state_q) == ST_AVAIL && $past(rma_cmd_i))); // R3

    AST_RETIRE_AFTER_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RETIRED && $past(state_q) == ST_WIPE) |-> $past(zlast_i)); // R6

    AST_POR_TO_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
        por_i |=> (state_q == ST_BOOT)); // R11

endmodule

// File: rtl/lcs_rma_seq.sv
module lcs_rma_seq #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          por_i,
    input  logic          otp_rma_set_i,
    input  logic          rma_cmd_i,
    input  logic          lcs_rd_i,
    output logic          lcs_valid_o,
    output logic [1:0]    lcs_rdata_o,
    output logic [1:0]    lcs_code_o,
    output logic          operable_o,
    output logic          err_o,
    input  logic          key_wr_i,
    input  logic          key_rd_i,
    input  logic [AW-1:0] key_addr_i,
    input  logic [DW-1:0] key_wdata_i,
    output logic [DW-1:0] key_rdata_o,
    output logic          key_rvalid_o,
    output logic          zero_busy_o,
    output logic          zero_done_o
);

    logic otp_flag, pend, ret;
    logic pend_set, ret_set;
    logic zreq, zlast, key_ok;
    logic lcs_valid_q;
    logic [1:0] lcs_rdata_q;

    lcs_nv_record u_nv (
        .clk        (clk),
        .rst_n      (rst_n),
        .otp_set_i  (otp_rma_set_i),
        .pend_set_i (pend_set),
        .ret_set_i  (ret_set),
        .otp_flag_o (otp_flag),
        .pend_o     (pend),
        .ret_o      (ret)
    );

    lcs_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .por_i      (por_i),
        .rma_cmd_i  (rma_cmd_i),
        .key_acc_i  (key_wr_i | key_rd_i),
        .otp_flag_i (otp_flag),
        .pend_i     (pend),
        .ret_i      (ret),
        .zlast_i    (zlast),
        .code_o     (lcs_code_o),
        .operable_o (operable_o),
        .key_ok_o   (key_ok),
        .zreq_o     (zreq),
        .pend_set_o (pend_set),
        .ret_set_o  (ret_set),
        .busy_o     (zero_busy_o),
        .err_o      (err_o)
    );

    lcs_keystore #(.DW(DW), .DEPTH(DEPTH)) u_ks (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (key_wr_i & key_ok),
        .rd_en_i  (key_rd_i & key_ok),
        .addr_i   (key_addr_i),
        .wdata_i  (key_wdata_i),
        .zreq_i   (zreq),
        .rdata_o  (key_rdata_o),
        .rvalid_o (key_rvalid_o),
        .zlast_o  (zlast),
        .zdone_o  (zero_done_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcs_valid_q <= 1'b0;
            lcs_rdata_q <= '0;
        end else begin
            lcs_valid_q <= lcs_rd_i;
            lcs_rdata_q <= lcs_rd_i ? lcs_code_o : '0;
        end
    end

    assign lcs_valid_o = lcs_valid_q;
    assign lcs_rdata_o = lcs_rdata_q;

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        lcs_rd_i |=> lcs_valid_o); // R9

    AST_NO_DATA_IN_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
        zero_busy_o |-> !key_rvalid_o); // R10

    AST_RETIRED_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (lcs_code_o == 2'b11) |-> !operable_o); // R8

    AST_BAD_CMD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (rma_cmd_i && lcs_code_o != 2'b01) |=> err_o); // R4

endmodule

// File: tb/lcs_rma_seq_test.sv
module lcs_rma_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 4;
    localparam int NVEC = 8;

    localparam logic [AW+DW-1:0] KVEC [NVEC] = '{
        {4'h0, 32'hA5A5_0001}, {4'hF, 32'h5A5A_FFFF},
        {4'h3, 32'h1234_5678}, {4'h7, 32'hDEAD_BEEF},
        {4'h8, 32'h0000_0001}, {4'hC, 32'h8000_0000},
        {4'h1, 32'hFFFF_FFFF}, {4'hA, 32'h0F0F_F0F0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por_i = 1'b0, otp_rma_set_i = 1'b0, rma_cmd_i = 1'b0, lcs_rd_i = 1'b0;
    logic key_wr_i = 1'b0, key_rd_i = 1'b0;
    logic [AW-1:0] key_addr_i = '0;
    logic [DW-1:0] key_wdata_i = '0;
    logic lcs_valid_o, operable_o, err_o, key_rvalid_o, zero_busy_o, zero_done_o;
    logic [1:0] lcs_rdata_o, lcs_code_o;
    logic [DW-1:0] key_rdata_o;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcs_rma_seq uut (
        .clk(clk), .rst_n(rst_n), .por_i(por_i), .otp_rma_set_i(otp_rma_set_i),
        .rma_cmd_i(rma_cmd_i), .lcs_rd_i(lcs_rd_i), .lcs_valid_o(lcs_valid_o),
        .lcs_rdata_o(lcs_rdata_o), .lcs_code_o(lcs_code_o), .operable_o(operable_o),
        .err_o(err_o), .key_wr_i(key_wr_i), .key_rd_i(key_rd_i),
        .key_addr_i(key_addr_i), .key_wdata_i(key_wdata_i), .key_rdata_o(key_rdata_o),
        .key_rvalid_o(key_rvalid_o), .zero_busy_o(zero_busy_o), .zero_done_o(zero_done_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int busy_n;
        int done_n;
        step(); step();
        rst_n = 1'b1;
        step(); step();
        chk("R1 code", lcs_code_o, 2'b00);
        chk("R1 operable", operable_o, 1'b1);
        chk("R1 err", err_o, 1'b0);

        // R12: vector table of writes then reads
        for (int i = 0; i < NVEC; i++) begin
            key_wr_i = 1'b1; key_addr_i = KVEC[i][AW+DW-1:DW]; key_wdata_i = KVEC[i][DW-1:0];
            step();
        end
        key_wr_i = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            key_rd_i = 1'b1; key_addr_i = KVEC[i][AW+DW-1:DW];
            step();
            chk("R12 rvalid", key_rvalid_o, 1'b1);
            chk("R12 rdata", key_rdata_o, KVEC[i][DW-1:0]);
        end
        key_rd_i = 1'b0;
        step();
        chk("R12 rvalid idle", key_rvalid_o, 1'b0);

        // R4: command in normal state
        rma_cmd_i = 1'b1; step(); rma_cmd_i = 1'b0;
        chk("R4 err normal", err_o, 1'b1);
        chk("R4 code normal", lcs_code_o, 2'b00);
        step();
        chk("R4 err one cycle", err_o, 1'b0);

        // R2: flag alone changes nothing
        otp_rma_set_i = 1'b1; step(); otp_rma_set_i = 1'b0;
        step();
        chk("R2 code before por", lcs_code_o, 2'b00);
        lcs_rd_i = 1'b1; step(); lcs_rd_i = 1'b0;
        chk("R9 valid normal", lcs_valid_o, 1'b1);
        chk("R9 rdata normal", lcs_rdata_o, 2'b00);

        por_i = 1'b1; step(); por_i = 1'b0;
        step();
        chk("R2 code after por", lcs_code_o, 2'b01);
        chk("R2 operable", operable_o, 1'b1);

        // R3: command in available state
        rma_cmd_i = 1'b1; step(); rma_cmd_i = 1'b0;
        chk("R3 code", lcs_code_o, 2'b10);
        chk("R3 operable", operable_o, 1'b1);
        chk("R3 err", err_o, 1'b0);
        rma_cmd_i = 1'b1; step(); rma_cmd_i = 1'b0;
        chk("R4 err pending", err_o, 1'b1);
        chk("R4 code pending", lcs_code_o, 2'b10);
        lcs_rd_i = 1'b1; step(); lcs_rd_i = 1'b0;
        chk("R9 rdata pending", lcs_rdata_o, 2'b10);

        // R10 and R11: start wipe, read during it, interrupt with por
        por_i = 1'b1; step(); por_i = 1'b0;
        step();
        chk("R5 busy start", zero_busy_o, 1'b1);
        chk("R5 operable low", operable_o, 1'b0);
        key_rd_i = 1'b1; key_addr_i = 4'h3; step(); key_rd_i = 1'b0;
        chk("R10 rvalid", key_rvalid_o, 1'b0);
        chk("R10 rdata", key_rdata_o, 32'h0);
        chk("R10 err", err_o, 1'b1);
        step(); step();
        por_i = 1'b1; step(); por_i = 1'b0;
        chk("R11 busy in boot", zero_busy_o, 1'b0);
        busy_n = 0; done_n = 0;
        for (int k = 0; k < 40; k++) begin
            step();
            if (zero_busy_o) busy_n++;
            if (zero_done_o) begin
                done_n++;
                chk("R6 code at done", lcs_code_o, 2'b11);
            end
        end
        chk("R11 R5 busy cycles", busy_n, 16);
        chk("R6 done pulses", done_n, 1);
        chk("R6 operable", operable_o, 1'b0);

        // R7: persistence
        por_i = 1'b1; step(); por_i = 1'b0;
        step(); step();
        chk("R7 code", lcs_code_o, 2'b11);
        chk("R7 busy", zero_busy_o, 1'b0);
        chk("R7 operable", operable_o, 1'b0);

        // R8: rejection when retired
        rma_cmd_i = 1'b1; step(); rma_cmd_i = 1'b0;
        chk("R8 err cmd", err_o, 1'b1);
        chk("R8 code", lcs_code_o, 2'b11);
        key_wr_i = 1'b1; key_addr_i = 4'h0; key_wdata_i = 32'h1; step(); key_wr_i = 1'b0;
        chk("R8 err wr", err_o, 1'b1);
        key_rd_i = 1'b1; step(); key_rd_i = 1'b0;
        chk("R8 err rd", err_o, 1'b1);
        chk("R8 rvalid", key_rvalid_o, 1'b0);
        lcs_rd_i = 1'b1; step(); lcs_rd_i = 1'b0;
        chk("R9 valid retired", lcs_valid_o, 1'b1);
        chk("R9 rdata retired", lcs_rdata_o, 2'b11);
        step();
        chk("R9 valid drops", lcs_valid_o, 1'b0);

        finish_run();
    end

endmodule